// File: doc/BRIEF.md
# SPI Bridge Command Responder

This block sits on the device side of a host-to-SPI bridge and interprets a byte stream of commands. Each command is one opcode byte followed by a fixed number of little-endian parameter bytes, all delivered over a ready/valid byte input. The block then returns a response frame over a ready/valid byte output.

Query commands report the following: a liveness acknowledge, a resynchronisation pair, the protocol version, a 256-bit map of supported opcodes, a 16-byte program name, the largest read and write chunk lengths, and the SPI capability record.

Setting commands update a register set that is driven straight to an SPI engine. That register set holds the clock half-divisor and applied frequency, the frame flags, the word width, the chip-select mask and level, and the pin-driver enable. Where a setting has a response payload, it echoes the value actually applied, not the value requested. Bulk data opcodes are not claimed in the map; a separate sequencer serves them.

Top module: `sprog_cmd_responder`

## Requirements
- R1: Opcode 0x00 answers the single byte 0x06 (ACK). Any opcode whose map bit is clear is handled as follows: it takes no parameter bytes, answers the single byte 0x15 (NAK), and leaves every cfg_* output unchanged.
- R2: Opcode 0x10 answers exactly two bytes, 0x15 then 0x06.
- R3: Opcode 0x01 answers 0x06, 0x01, 0x00 (version 1, low byte first).
- R4: Opcode 0x02 answers 0x06 followed by 32 map bytes. Bit (op & 7) of map byte (op >> 3) is 1 exactly for the supported set {0x00,0x01,0x02,0x03,0x08,0x10,0x11,0x14,0x15,0x40,0x41,0x42,0x43,0x44}.
- R5: Opcode 0x03 answers 0x06 plus the 16 ASCII bytes "spi bridge resp0". Opcode 0x08 answers 0x06 plus the write limit (default 256) as 3 little-endian bytes. Opcode 0x11 answers 0x06 plus the read limit (default 512) in the same 3-byte form.
- R6: Opcode 0x40 answers 14 bytes in this order: 0x06; the minimum frequency (32-bit LE); the maximum frequency (32-bit LE); capability bits 0x039F (16-bit LE); chip-select count; minimum word width; maximum word width. With the defaults, the minimum frequency is 366, the maximum is 24000000, and the last three bytes are 4, 4 and 16.
- R7: Opcode 0x14 takes a 32-bit LE request f. The half-divisor is k = floor((SYS_CLK_HZ + f) / (2f)), clamped to 1..2^DIV_W-1; a request of 0 gives the maximum k. The applied frequency is SYS_CLK_HZ / (2k). The response is 0x06 plus the applied frequency as 32-bit LE, and cfg_half_div and cfg_freq take k and the applied frequency.
- R8: Opcode 0x43 takes one byte b. It applies b & 0x33 (mode bits 1:0, LSB-first bit 4, chip-select-high bit 5) to cfg_flags and answers 0x06 plus the applied byte.
- R9: Opcode 0x44 takes one byte. It applies that byte clamped to MIN_BPW..MAX_BPW (defaults 4..16) to cfg_bpw and answers 0x06 plus the applied byte.
- R10: Opcode 0x41 takes a mask byte and applies it ANDed with the low NUM_CS bits to cfg_cs_mask. Opcode 0x42 takes a level byte and applies its bit 0 to cfg_cs_level. Both answer a single 0x06.
- R11: Opcode 0x15 takes one byte. It sets cfg_pins_en to 1 if the byte is nonzero and to 0 otherwise, and answers 0x06 plus the applied value (0x01 or 0x00).
- R12: in_ready is low whenever out_valid is high. A response byte with out_valid high and out_ready low holds its value until it is taken.
- R13: After reset, the outputs take these values: in_ready=1, out_valid=0, cfg_half_div=2^DIV_W-1, cfg_freq equal to the minimum frequency, cfg_flags=0, cfg_bpw=8, cfg_cs_mask=0, cfg_cs_level=0, cfg_pins_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command byte offered |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Block accepts a command byte |
| out_valid | output | 1 | Response byte offered |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | Consumer takes the response byte |
| cfg_freq | output | 32 | Applied SPI clock frequency in Hz |
| cfg_half_div | output | DIV_W | Applied half-divisor k |
| cfg_flags | output | 8 | Applied frame flags |
| cfg_bpw | output | 8 | Applied bits per word |
| cfg_cs_mask | output | 8 | Applied chip-select mask |
| cfg_cs_level | output | 1 | Applied chip-select level |
| cfg_pins_en | output | 1 | Pin drivers enabled |

## Verification
The checker watches several properties on every cycle. The output handshake must never drop or alter a stalled byte, and input and output must never be open at the same time. The applied half-divisor, word width, chip-select mask and flag bits must stay within their legal sets. The settings may change only in the single cycle between a completed command and its response. The exact content of each response frame is shown only by the bench's scenarios: the divider rounding and clamping, the map bit layout and the name string. The same holds for the rule that an unknown opcode leaves the settings untouched.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

    localparam logic [7:0]   ACK        = 8'h06;
    localparam logic [7:0]   NAK        = 8'h15;
    localparam logic [15:0]  IFACE_VER  = 16'h0001;
    localparam logic [7:0]   FLAG_KEEP  = 8'h33;
    localparam logic [15:0]  CAP_BITS   = 16'h039F;
    localparam logic [127:0] PROG_NAME  = "spi bridge resp0";

    typedef enum logic [7:0] {
        OP_NOP    = 8'h00,
        OP_IFACE  = 8'h01,
        OP_CMDMAP = 8'h02,
        OP_NAME   = 8'h03,
        OP_WRMAX  = 8'h08,
        OP_SYNC   = 8'h10,
        OP_RDMAX  = 8'h11,
        OP_FREQ   = 8'h14,
        OP_PINS   = 8'h15,
        OP_CAPS   = 8'h40,
        OP_CSMASK = 8'h41,
        OP_CSLVL  = 8'h42,
        OP_FLAGS  = 8'h43,
        OP_BPW    = 8'h44
    } opcode_e;

    typedef enum logic [1:0] {
        ST_OPCODE,
        ST_ARGS,
        ST_APPLY,
        ST_REPLY
    } state_e;

    typedef struct packed {
        logic [31:0] freq;
        logic [7:0]  flags;
        logic [7:0]  bpw;
        logic [7:0]  cs_mask;
        logic        cs_level;
        logic        pins_en;
    } spi_cfg_t;

    function automatic logic op_known(input logic [7:0] op);
        case (op)
            OP_NOP, OP_IFACE, OP_CMDMAP, OP_NAME, OP_WRMAX, OP_SYNC,
            OP_RDMAX, OP_FREQ, OP_PINS, OP_CAPS, OP_CSMASK, OP_CSLVL,
            OP_FLAGS, OP_BPW: return 1'b1;
            default:          return 1'b0;
        endcase
    endfunction

    function automatic logic [2:0] op_arg_len(input logic [7:0] op);
        case (op)
            OP_FREQ:                                        return 3'd4;
            OP_PINS, OP_CSMASK, OP_CSLVL, OP_FLAGS, OP_BPW: return 3'd1;
            default:                                        return 3'd0;
        endcase
    endfunction

    function automatic logic [5:0] op_rsp_len(input logic [7:0] op);
        case (op)
            OP_SYNC:                     return 6'd2;
            OP_IFACE:                    return 6'd3;
            OP_CMDMAP:                   return 6'd33;
            OP_NAME:                     return 6'd17;
            OP_WRMAX, OP_RDMAX:          return 6'd4;
            OP_CAPS:                     return 6'd14;
            OP_FREQ:                     return 6'd5;
            OP_FLAGS, OP_BPW, OP_PINS:   return 6'd2;
            default:                     return 6'd1;
        endcase
    endfunction

endpackage

// File: rtl/sprog_clk_fit.sv
module sprog_clk_fit #(
    parameter int unsigned SYS_CLK_HZ = 48_000_000,
    parameter int unsigned DIV_W      = 16
) (
    input  logic [31:0]      req_hz,
    output logic [DIV_W-1:0] half_div,
    output logic [31:0]      applied_hz
);
    localparam logic [63:0] MAX_K = 64'((64'd1 << DIV_W) - 64'd1);
    localparam logic [63:0] SYS   = 64'(SYS_CLK_HZ);

    logic [63:0] num, den, k_raw, k_clamped, freq_wide;

    always_comb begin
        num = SYS + 64'(req_hz);
        den = (req_hz == 32'd0) ? 64'd1 : {31'd0, req_hz, 1'b0};
        k_raw = (req_hz == 32'd0) ? MAX_K : num / den;
        if (k_raw == 64'd0)
            k_clamped = 64'd1;
        else if (k_raw > MAX_K)
            k_clamped = MAX_K;
        else
            k_clamped = k_raw;
        freq_wide  = SYS / {k_clamped[62:0], 1'b0};
        half_div   = k_clamped[DIV_W-1:0];
        applied_hz = freq_wide[31:0];
    end
endmodule

// File: rtl/sprog_reply_mux.sv
module sprog_reply_mux
    import sprog_pkg::*;
#(
    parameter int unsigned FREQ_MIN   = 366,
    parameter int unsigned FREQ_MAX   = 24_000_000,
    parameter int unsigned NUM_CS     = 4,
    parameter int unsigned MIN_BPW    = 4,
    parameter int unsigned MAX_BPW    = 16,
    parameter int unsigned WR_MAX_LEN = 256,
    parameter int unsigned RD_MAX_LEN = 512
) (
    input  logic [7:0] op,
    input  logic [5:0] idx,
    input  spi_cfg_t   cfg,
    output logic [7:0] reply
);
    logic [127:0] frame;
    logic [127:0] shifted;
    logic [127:0] name_sh;
    logic [5:0]   idx_m1;
    logic [7:0]   map_byte;

    always_comb begin
        idx_m1 = idx - 6'd1;
        for (int j = 0; j < 8; j++) begin
            map_byte[j] = op_known({idx_m1[4:0], 3'(j)});
        end
        name_sh = PROG_NAME << {idx_m1[3:0], 3'b000};

        case (op)
            OP_NOP:    frame = {120'd0, ACK};
            OP_SYNC:   frame = {112'd0, ACK, NAK};
            OP_IFACE:  frame = {104'd0, IFACE_VER, ACK};
            OP_WRMAX:  frame = {96'd0, 24'(WR_MAX_LEN), ACK};
            OP_RDMAX:  frame = {96'd0, 24'(RD_MAX_LEN), ACK};
            OP_CAPS:   frame = {16'd0, 8'(MAX_BPW), 8'(MIN_BPW), 8'(NUM_CS),
                                CAP_BITS, 32'(FREQ_MAX), 32'(FREQ_MIN), ACK};
            OP_FREQ:   frame = {88'd0, cfg.freq, ACK};
            OP_FLAGS:  frame = {112'd0, cfg.flags, ACK};
            OP_BPW:    frame = {112'd0, cfg.bpw, ACK};
            OP_PINS:   frame = {112'd0, 7'd0, cfg.pins_en, ACK};
            OP_CSMASK, OP_CSLVL, OP_CMDMAP, OP_NAME:
                       frame = {120'd0, ACK};
            default:   frame = {120'd0, NAK};
        endcase
        shifted = frame >> {idx[3:0], 3'b000};

        if (op == OP_CMDMAP && idx != 6'd0)
            reply = map_byte;
        else if (op == OP_NAME && idx != 6'd0)
            reply = name_sh[127:120];
        else
            reply = shifted[7:0];
    end
endmodule

// File: rtl/sprog_cmd_responder.sv
module sprog_cmd_responder
    import sprog_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 48_000_000,
    parameter int unsigned DIV_W      = 16,
    parameter int unsigned NUM_CS     = 4,
    parameter int unsigned MIN_BPW    = 4,
    parameter int unsigned MAX_BPW    = 16,
    parameter int unsigned WR_MAX_LEN = 256,
    parameter int unsigned RD_MAX_LEN = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    input  logic             out_ready,
    output logic [31:0]      cfg_freq,
    output logic [DIV_W-1:0] cfg_half_div,
    output logic [7:0]       cfg_flags,
    output logic [7:0]       cfg_bpw,
    output logic [7:0]       cfg_cs_mask,
    output logic             cfg_cs_level,
    output logic             cfg_pins_en
);
    localparam int unsigned MAX_HALF_DIV = (1 << DIV_W) - 1;
    localparam int unsigned FREQ_MIN     = SYS_CLK_HZ / (2 * MAX_HALF_DIV);
    localparam int unsigned FREQ_MAX     = SYS_CLK_HZ / 2;
    localparam logic [7:0]  CS_ALL       = 8'((1 << NUM_CS) - 1);

    state_e           state;
    logic [7:0]       op;
    logic [31:0]      arg;
    logic [1:0]       arg_cnt;
    logic [5:0]       idx;
    spi_cfg_t         cfg;
    logic [DIV_W-1:0] half_div;
    logic [DIV_W-1:0] fit_div;
    logic [31:0]      fit_hz;
    logic [7:0]       reply;

    sprog_clk_fit #(
        .SYS_CLK_HZ (SYS_CLK_HZ),
        .DIV_W      (DIV_W)
    ) i_clk_fit (
        .req_hz     (arg),
        .half_div   (fit_div),
        .applied_hz (fit_hz)
    );

    sprog_reply_mux #(
        .FREQ_MIN   (FREQ_MIN),
        .FREQ_MAX   (FREQ_MAX),
        .NUM_CS     (NUM_CS),
        .MIN_BPW    (MIN_BPW),
        .MAX_BPW    (MAX_BPW),
        .WR_MAX_LEN (WR_MAX_LEN),
        .RD_MAX_LEN (RD_MAX_LEN)
    ) i_reply_mux (
        .op    (op),
        .idx   (idx),
        .cfg   (cfg),
        .reply (reply)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_OPCODE;
            op       <= 8'h00;
            arg      <= 32'd0;
            arg_cnt  <= 2'd0;
            idx      <= 6'd0;
            half_div <= DIV_W'(MAX_HALF_DIV);
            cfg      <= '{freq: 32'(FREQ_MIN), flags: 8'h00, bpw: 8'd8,
                          cs_mask: 8'h00, cs_level: 1'b0, pins_en: 1'b0};
        end else begin
            case (state)
                ST_OPCODE: if (in_valid) begin
                    op      <= in_data;
                    arg_cnt <= 2'd0;
                    state   <= (op_arg_len(in_data) == 3'd0) ? ST_APPLY : ST_ARGS;
                end
                ST_ARGS: if (in_valid) begin
                    arg[{arg_cnt, 3'b000} +: 8] <= in_data;
                    arg_cnt <= arg_cnt + 2'd1;
                    if ({1'b0, arg_cnt} == op_arg_len(op) - 3'd1)
                        state <= ST_APPLY;
                end
                ST_APPLY: begin
                    idx   <= 6'd0;
                    state <= ST_REPLY;
                    case (op)
                        OP_FREQ: begin
                            cfg.freq <= fit_hz;
                            half_div <= fit_div;
                        end
                        OP_FLAGS:  cfg.flags <= arg[7:0] & FLAG_KEEP;
                        OP_BPW: begin
                            if (arg[7:0] < 8'(MIN_BPW))
                                cfg.bpw <= 8'(MIN_BPW);
                            else if (arg[7:0] > 8'(MAX_BPW))
                                cfg.bpw <= 8'(MAX_BPW);
                            else
                                cfg.bpw <= arg[7:0];
                        end
                        OP_CSMASK: cfg.cs_mask  <= arg[7:0] & CS_ALL;
                        OP_CSLVL:  cfg.cs_level <= arg[0];
                        OP_PINS:   cfg.pins_en  <= |arg[7:0];
                        default: ;
                    endcase
                end
                ST_REPLY: if (out_ready) begin
                    if (idx == op_rsp_len(op) - 6'd1)
                        state <= ST_OPCODE;
                    else
                        idx <= idx + 6'd1;
                end
                default: state <= ST_OPCODE;
            endcase
        end
    end

    assign in_ready     = (state == ST_OPCODE) || (state == ST_ARGS);
    assign out_valid    = (state == ST_REPLY);
    assign out_data     = reply;
    assign cfg_freq     = cfg.freq;
    assign cfg_half_div = half_div;
    assign cfg_flags    = cfg.flags;
    assign cfg_bpw      = cfg.bpw;
    assign cfg_cs_mask  = cfg.cs_mask;
    assign cfg_cs_level = cfg.cs_level;
    assign cfg_pins_en  = cfg.pins_en;
endmodule

// File: rtl/sprog_cmd_checker.sv
module sprog_cmd_checker
    import sprog_pkg::*;
#(
    parameter int unsigned DIV_W   = 16,
    parameter int unsigned NUM_CS  = 4,
    parameter int unsigned MIN_BPW = 4,
    parameter int unsigned MAX_BPW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic [DIV_W-1:0] cfg_half_div,
    input logic [7:0]       cfg_flags,
    input logic [7:0]       cfg_bpw,
    input logic [7:0]       cfg_cs_mask
);
    localparam logic [7:0] CS_ALL = 8'((1 << NUM_CS) - 1);

    assert_stall_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_one_side_R12: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    assert_div_range_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_half_div != '0));

    assert_bpw_range_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_bpw >= 8'(MIN_BPW)) && (cfg_bpw <= 8'(MAX_BPW)));

    assert_cs_mask_R10: assert property (@(posedge clk) disable iff (rst)
        ((cfg_cs_mask & ~CS_ALL) == 8'h00));

    assert_flags_legal_R8: assert property (@(posedge clk) disable iff (rst)
        ((cfg_flags & ~FLAG_KEEP) == 8'h00));

    assert_cfg_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (!$stable(cfg_flags) || !$stable(cfg_bpw) || !$stable(cfg_cs_mask))
            |-> $past(!in_ready && !out_valid));
endmodule

bind sprog_cmd_responder sprog_cmd_checker #(
    .DIV_W   (DIV_W),
    .NUM_CS  (NUM_CS),
    .MIN_BPW (MIN_BPW),
    .MAX_BPW (MAX_BPW)
) i_sprog_cmd_checker (
    .clk          (clk),
    .rst          (rst),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .cfg_half_div (cfg_half_div),
    .cfg_flags    (cfg_flags),
    .cfg_bpw      (cfg_bpw),
    .cfg_cs_mask  (cfg_cs_mask)
);

// File: tb/test_sprog_cmd_responder.sv
module test_sprog_cmd_responder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50_000;
    localparam logic [127:0] NAME_EXP = "spi bridge resp0";

    typedef struct packed {
        logic [7:0]   req;
        logic [2:0]   nin;
        logic [39:0]  cin;
        logic [4:0]   nout;
        logic [111:0] exp;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [0:NV-1] = '{
        '{8'd1,  3'd1, 40'h00,          5'd1,  112'h06},                 // R1 no-op
        '{8'd2,  3'd1, 40'h10,          5'd2,  112'h0615},               // R2 sync pair
        '{8'd3,  3'd1, 40'h01,          5'd3,  112'h000106},             // R3 version
        '{8'd5,  3'd1, 40'h08,          5'd4,  112'h00010006},           // R5 write limit
        '{8'd5,  3'd1, 40'h11,          5'd4,  112'h00020006},           // R5 read limit
        '{8'd6,  3'd1, 40'h40,          5'd14, 112'h1004_0403_9F01_6E36_0000_0001_6E06}, // R6 caps
        '{8'd7,  3'd5, 40'h00_0F42_4014, 5'd5, 112'h00_0F42_4006},       // R7 exact 1 MHz
        '{8'd7,  3'd5, 40'h00_6ACF_C014, 5'd5, 112'h00_7A12_0006},       // R7 7 MHz -> 8 MHz
        '{8'd7,  3'd5, 40'h00_0000_0014, 5'd5, 112'h00_0001_6E06},       // R7 zero -> minimum
        '{8'd7,  3'd5, 40'h05_F5E1_0014, 5'd5, 112'h01_6E36_0006},       // R7 above max -> max
        '{8'd8,  3'd2, 40'hFF43,        5'd2,  112'h3306},               // R8 all flags
        '{8'd8,  3'd2, 40'h1143,        5'd2,  112'h1106},               // R8 legal flags
        '{8'd9,  3'd2, 40'h0244,        5'd2,  112'h0406},               // R9 below min
        '{8'd9,  3'd2, 40'h2844,        5'd2,  112'h1006},               // R9 above max
        '{8'd9,  3'd2, 40'h0C44,        5'd2,  112'h0C06},               // R9 in range
        '{8'd10, 3'd2, 40'hFF41,        5'd1,  112'h06},                 // R10 mask
        '{8'd10, 3'd2, 40'h0142,        5'd1,  112'h06},                 // R10 level
        '{8'd11, 3'd2, 40'h0515,        5'd2,  112'h0106},               // R11 enable
        '{8'd11, 3'd2, 40'h0015,        5'd2,  112'h0006},               // R11 disable
        '{8'd1,  3'd1, 40'h13,          5'd1,  112'h15},                 // R1 unknown
        '{8'd1,  3'd1, 40'hFF,          5'd1,  112'h15}                  // R1 unknown
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;
    logic [31:0] cfg_freq;
    logic [15:0] cfg_half_div;
    logic [7:0]  cfg_flags;
    logic [7:0]  cfg_bpw;
    logic [7:0]  cfg_cs_mask;
    logic        cfg_cs_level;
    logic        cfg_pins_en;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sprog_cmd_responder i_sprog_cmd_responder (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_ready    (out_ready),
        .cfg_freq     (cfg_freq),
        .cfg_half_div (cfg_half_div),
        .cfg_flags    (cfg_flags),
        .cfg_bpw      (cfg_bpw),
        .cfg_cs_mask  (cfg_cs_mask),
        .cfg_cs_level (cfg_cs_level),
        .cfg_pins_en  (cfg_pins_en)
    );

    function automatic logic bench_known(input int op);
        case (op)
            'h00, 'h01, 'h02, 'h03, 'h08, 'h10, 'h11, 'h14, 'h15,
            'h40, 'h41, 'h42, 'h43, 'h44: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        in_data  = b;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b);
        out_ready = 1'b1;
        while (!out_valid) @(negedge clk);
        b = out_data;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic cfg_snapshot(input string tag, input logic [31:0] f, input logic [15:0] k,
                                input logic [7:0] fl, input logic [7:0] bw,
                                input logic [7:0] m, input logic lv, input logic pe);
        check(tag, {cfg_freq, cfg_half_div, cfg_flags, cfg_bpw, cfg_cs_mask, cfg_cs_level, cfg_pins_en},
                   {f, k, fl, bw, m, lv, pe});
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R12 watchdog: actual hung expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0]   b;
        logic [111:0] got;
        logic [7:0]   map_exp;
        logic         map_ok;
        logic         name_ok;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13 reset state
        check("R13 handshake", {in_ready, out_valid}, {1'b1, 1'b0});
        cfg_snapshot("R13 settings", 32'd366, 16'hFFFF, 8'h00, 8'd8, 8'h00, 1'b0, 1'b0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            for (int j = 0; j < int'(VECS[i].nin); j++) send_byte(VECS[i].cin[8*j +: 8]);
            got = '0;
            for (int j = 0; j < int'(VECS[i].nout); j++) begin
                recv_byte(b);
                got[8*j +: 8] = b;
            end
            check($sformatf("R%0d vector %0d", VECS[i].req, i), 128'(got), 128'(VECS[i].exp));
        end

        // R10 applied mask and level visible on ports; R1 unknown opcodes changed nothing
        cfg_snapshot("R10/R1 settings after table", 32'd24_000_000, 16'd1, 8'h11, 8'h0C,
                     8'h0F, 1'b1, 1'b0);

        // R7 half-divisor for 1 MHz
        send_byte(8'h14); send_byte(8'h40); send_byte(8'h42); send_byte(8'h0F); send_byte(8'h00);
        for (int j = 0; j < 5; j++) recv_byte(b);
        check("R7 divisor", {cfg_half_div, cfg_freq}, {16'd24, 32'd1_000_000});

        // R1 unknown opcode followed by settings check
        send_byte(8'h20);
        recv_byte(b);
        check("R1 unknown nak", b, 8'h15);
        cfg_snapshot("R1 no change", 32'd1_000_000, 16'd24, 8'h11, 8'h0C, 8'h0F, 1'b1, 1'b0);

        // R4 opcode map
        send_byte(8'h02);
        recv_byte(b);
        check("R4 map ack", b, 8'h06);
        map_ok = 1'b1;
        for (int j = 0; j < 32; j++) begin
            recv_byte(b);
            for (int t = 0; t < 8; t++) map_exp[t] = bench_known(8*j + t);
            if (b !== map_exp) begin
                map_ok = 1'b0;
                $display("map byte %0d actual %0h expected %0h", j, b, map_exp);
            end
        end
        check("R4 map bytes", map_ok, 1'b1);
        check("R12 idle after map", {in_ready, out_valid}, {1'b1, 1'b0});

        // R5 name
        send_byte(8'h03);
        recv_byte(b);
        check("R5 name ack", b, 8'h06);
        name_ok = 1'b1;
        for (int j = 0; j < 16; j++) begin
            recv_byte(b);
            if (b !== NAME_EXP[127-8*j -: 8]) name_ok = 1'b0;
        end
        check("R5 name bytes", name_ok, 1'b1);

        // R12 backpressure
        send_byte(8'h01);
        @(negedge clk);
        check("R12 stall first", {out_valid, in_ready, out_data}, {1'b1, 1'b0, 8'h06});
        repeat (3) @(negedge clk);
        check("R12 stall held", {out_valid, in_ready, out_data}, {1'b1, 1'b0, 8'h06});
        got = '0;
        for (int j = 0; j < 3; j++) begin
            recv_byte(b);
            got[8*j +: 8] = b;
        end
        check("R12 frame after stall", 128'(got), 128'h000106);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule